// File: doc/BRIEF.md
# Dual-Modulus Divide-by-22/23 Prescaler

This block divides a fast clock by 22 or 23. A modulus-control input picks the ratio: low gives 22 and high gives 23. An external pulse-swallow counter drives that input once per output period to step a synthesizer's feedback ratio.

The divider is a chain of three divide-by-2/3 cells followed by a divide-by-2 stage. Each stage advances only on the cycle in which the stage before it completes a period. A cell stretches a period to three of its input ticks only when the period starts at a frame boundary and the cell's modulus bit is set. The second and third cells are tied to stretch in every frame, which gives the nominal 22. The first cell's bit comes from the modulus control, which adds one fast cycle when it is set.

The modulus control is sampled only on the clock edge that ends a frame, and on every edge while reset is held. A change that arrives in the middle of a frame therefore waits for the next full period.

Top module: `dm_prescaler`

## Requirements
- R1: With the modulus control low at a frame-ending edge, the next `pulse_o` comes exactly 22 clock edges after the current one.
- R2: With the modulus control high at a frame-ending edge, the next `pulse_o` comes exactly 23 clock edges after the current one.
- R3: `pulse_o` is high for exactly one clock cycle per output period, and is never high in two consecutive cycles.
- R4: The modulus control has no effect at any edge other than a frame-ending edge (the edge at which `pulse_o` rises) or an edge with reset high. Changing it mid-frame leaves the current period length unchanged.
- R5: After synchronous reset is released, the first `pulse_o` comes 22 or 23 edges after the last edge with reset high, following the modulus control sampled at that edge.
- R6: `div_clk_o` is low from the start of a frame until 14 edges into it (15 when the frame's modulus was high). It then stays high for 8 edges and falls on the frame-ending edge together with the rise of `pulse_o`.
- R7: While reset is held, `pulse_o` and `div_clk_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mc_i | input | 1 | Modulus control: 0 selects 22, 1 selects 23 |
| pulse_o | output | 1 | One-cycle pulse at each frame end |
| div_clk_o | output | 1 | Divided clock, falling at each frame end |

## Verification
Two things can happen at one clock edge: the end of a frame, and a change on the modulus control that is meant for the next frame. The modulus control may flip on the very edge that ends a frame, or at random mid-frame points. The bench drives it on falling edges at random phases and, in a toggle mode, right after each pulse. Each period is judged against the value present at the previous frame-ending edge, and every mid-frame value is ignored.

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int NCELL = 3,
  parameter logic [NCELL-1:0] FIXED_STRETCH = 3'b110
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mc_i,
  output logic pulse_o,
  output logic div_clk_o
);

  function automatic int nominal_len();
    int s;
    s = 2 ** (NCELL + 1);
    for (int i = 0; i < NCELL; i++)
      if (FIXED_STRETCH[i]) s += 2 ** i;
    return s;
  endfunction

  localparam int NOMINAL = nominal_len();
  localparam int GW = $clog2(NOMINAL + 2);

  logic [NCELL:0]   tick;
  logic [NCELL-1:0] stretch_sel;
  logic             half_q;
  logic             frame;

  assign tick[0]     = 1'b1;
  assign stretch_sel = FIXED_STRETCH | NCELL'(mc_i);
  assign frame       = tick[NCELL] & half_q;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [1:0] cnt_q;
    logic       long_q;
    logic       wrap;

    assign wrap        = long_q ? (cnt_q == 2'd2) : (cnt_q == 2'd1);
    assign tick[i+1]   = tick[i] & wrap;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cnt_q  <= '0;
        long_q <= stretch_sel[i];
      end else if (tick[i]) begin
        if (wrap) begin
          cnt_q  <= '0;
          long_q <= frame & stretch_sel[i];
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end

    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q != 2'd3);

    // R4: a cell only takes a long period when it wraps at a frame boundary
    p_long_at_frame_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick[i] & wrap & ~frame) |=> !long_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      half_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      if (tick[NCELL]) half_q <= ~half_q;
      pulse_o <= frame;
    end
  end

  assign div_clk_o = half_q;

  logic [GW-1:0] gap_q;
  logic          mcf_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || frame) begin
      gap_q <= '0;
      mcf_q <= mc_i;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1 and R2: frame length follows the sampled modulus
  p_frame_len_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    frame |-> (gap_q == GW'(NOMINAL - 1) + GW'(mcf_q)));

  p_no_early_frame_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (gap_q < GW'(NOMINAL - 1)) |-> !frame);

  p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  p_div_fall_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(div_clk_o) |-> pulse_o);

endmodule

// File: tb/dm_prescaler_tb.sv
`timescale 1ns/1ps
module dm_prescaler_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc  = 1'b0;
  logic pulse, div_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dm_prescaler u_dut (
    .clk_i(clk), .rst_i(rst), .mc_i(mc),
    .pulse_o(pulse), .div_clk_o(div_clk)
  );

  function automatic int exp_period(input logic m);
    return 22 + int'(m);
  endfunction

  function automatic int exp_rise(input logic m);
    return 14 + int'(m);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  int   gap = 0;
  int   plen = 22;
  logic mcf = 1'b0;
  bit   first = 1'b1;
  bit   moved = 1'b0;
  logic prev_pulse = 1'b0;

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst) begin
      check("R7 pulse in reset", int'(pulse), 0);
      check("R7 div in reset", int'(div_clk), 0);
      gap = 0; mcf = mc; plen = exp_period(mc); first = 1'b1; moved = 1'b0;
    end else begin
      gap++;
      if (prev_pulse) check("R3 pulse width", int'(pulse), 0);
      if (gap == plen) begin
        if (first) check("R5 first pulse after reset", int'(pulse), 1);
        else if (moved) check("R4 mid-frame change ignored", int'(pulse), 1);
        else if (mcf) check("R2 period 23", int'(pulse), 1);
        else check("R1 period 22", int'(pulse), 1);
        check("R6 div falls at frame end", int'(div_clk), 0);
        gap = 0; mcf = mc; plen = exp_period(mc); first = 1'b0; moved = 1'b0;
      end else begin
        if (mc != mcf) moved = 1'b1;
        if (pulse) check(mcf ? "R2 early pulse" : "R1 early pulse", 1, 0);
        if (gap == exp_rise(mcf) - 1 || gap == exp_rise(mcf))
          check("R6 div rise", int'(div_clk), int'(gap >= exp_rise(mcf)));
        else if (div_clk != (gap >= exp_rise(mcf)))
          check("R6 div level", int'(div_clk), int'(gap >= exp_rise(mcf)));
      end
    end
    prev_pulse = pulse;
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mc = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) wait_pulse();
    mc = 1'b1;
    for (int i = 0; i < 6; i++) wait_pulse();
    for (int i = 0; i < 12; i++) begin
      mc = ~mc;
      wait_pulse();
    end
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if ($urandom % 5 == 0) mc = 1'(($urandom % 2));
    end
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) wait_pulse();
    do_reset(1'b0);
    repeat (8) @(negedge clk);
    mc = 1'b1;
    repeat (4) @(negedge clk);
    mc = 1'b0;
    for (int i = 0; i < 3; i++) wait_pulse();
    repeat (7) @(negedge clk);
    do_reset(1'b1);
    repeat (10) @(negedge clk);
    mc = 1'b0;
    for (int i = 0; i < 3; i++) wait_pulse();
    for (int i = 0; i < 10; i++) begin
      wait_pulse();
      repeat ($urandom % 22) @(negedge clk);
      mc = 1'(($urandom % 2));
    end
    repeat (30) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule